// File: doc/BRIEF.md
# Packed Narrow-and-Interleave Unit

This block reshapes the lanes of a 64-bit packed-integer datapath. It has two families of operation. The narrowing family takes every element of two 64-bit operands and halves its width with saturation, so that both operands fit into one 64-bit result. It narrows signed doublewords to signed words, signed words to signed bytes, or signed words to unsigned bytes. The interleaving family takes either the upper or the lower 32 bits of both operands and merges them element by element into one 64-bit result, at byte, word or doubleword granularity.

The operation is chosen by a 4-bit code that arrives with the operands. The result is computed combinationally and captured in an output register. A valid flag travels with it, one cycle behind the input. Instruction decode and memory operands belong to the surrounding pipeline.

Top module: `pkpu_top`

## Requirements
- R1: While `rst` is high at a clock edge, the next `out_valid` is 0 and `out_result` is all zeros.
- R2: `out_valid` equals `in_valid` of the previous cycle. When `in_valid` is 1, `out_result` in the next cycle holds the result of that input.
- R3: When `in_valid` is 0, `out_result` keeps its value in the next cycle.
- R4: Code 0 narrows each 32-bit signed element to 16 bits. Values above 32767 give 0x7FFF, values below -32768 give 0x8000, and all other values are kept.
- R5: Code 1 narrows each 16-bit signed element to a signed byte. Values above 127 give 0x7F, values below -128 give 0x80, and all other values are kept.
- R6: Code 2 reads each 16-bit element as signed and narrows it to an unsigned byte. Negative values give 0x00, values above 255 give 0xFF, and all other values are kept.
- R7: In every narrowing result, the narrowed elements of `in_a` fill bits 31:0 and those of `in_b` fill bits 63:32. Element k of each operand goes to element k of its half.
- R8: Codes 4, 5 and 6 interleave the lower 32 bits of both operands at 8-, 16- and 32-bit granularity.
- R9: Codes 8, 9 and 10 interleave the upper 32 bits of both operands at 8-, 16- and 32-bit granularity. For code 10, result bits 31:0 hold `in_a[63:32]` and bits 63:32 hold `in_b[63:32]`.
- R10: In every interleave, element k of the chosen half of `in_a` goes to result element 2k, and element k of the chosen half of `in_b` goes to result element 2k+1.
- R11: Codes 3, 7 and 11 to 15 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and code are valid this cycle |
| in_op | input | 4 | Operation code |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_valid | output | 1 | Registered valid flag |
| out_result | output | 64 | Registered result |

## Verification
The bench drives saturation edges in every element position: 32767 and 32768, -32768 and -32769, 127 and 128, 255 and 256, -1 and 0x8000. A design that truncates instead of saturating, or that reads the unsigned-byte source as unsigned, returns wrong bytes at exactly these values. All-distinct byte patterns expose swapped operands, a wrong source half and a wrong pair order during interleaving, because each such fault moves a known byte to a position the model rejects. Idle cycles between operations catch a result register that loads without `in_valid`. Reserved codes catch a decoder that reuses a neighbouring operation.

// File: rtl/pkpu_pkg.sv
package pkpu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_PK_DW   = 4'd0,
        OP_PK_WB_S = 4'd1,
        OP_PK_WB_U = 4'd2,
        OP_UP_LO_B = 4'd4,
        OP_UP_LO_W = 4'd5,
        OP_UP_LO_D = 4'd6,
        OP_UP_HI_B = 4'd8,
        OP_UP_HI_W = 4'd9,
        OP_UP_HI_D = 4'd10
    } op_e;

    typedef enum logic [1:0] {
        FAM_NONE,
        FAM_PACK,
        FAM_UNPK
    } fam_e;

    typedef struct packed {
        fam_e       fam;
        logic       hi;
        logic [1:0] sel;
    } dec_t;

    function automatic dec_t decode(input logic [OP_W-1:0] op);
        dec_t d;
        d.hi  = op[3];
        d.sel = op[1:0];
        if (op[1:0] == 2'd3)
            d.fam = FAM_NONE;
        else if (op[3:2] == 2'b00)
            d.fam = FAM_PACK;
        else if (op[3:2] == 2'b01 || op[3:2] == 2'b10)
            d.fam = FAM_UNPK;
        else
            d.fam = FAM_NONE;
        return d;
    endfunction

    function automatic logic [15:0] sat_s16(input logic [31:0] v);
        if ($signed(v) > 32'sd32767)
            return 16'h7fff;
        else if ($signed(v) < -32'sd32768)
            return 16'h8000;
        else
            return v[15:0];
    endfunction

    function automatic logic [7:0] sat_s8(input logic [15:0] v);
        if ($signed(v) > 16'sd127)
            return 8'h7f;
        else if ($signed(v) < -16'sd128)
            return 8'h80;
        else
            return v[7:0];
    endfunction

    function automatic logic [7:0] sat_u8(input logic [15:0] v);
        if (v[15])
            return 8'h00;
        else if ($signed(v) > 16'sd255)
            return 8'hff;
        else
            return v[7:0];
    endfunction

endpackage

// File: rtl/pkpu_pack.sv
module pkpu_pack
    import pkpu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    localparam int HALF = DATA_W / 2;
    localparam int N_DW = DATA_W / 32;
    localparam int N_WD = DATA_W / 16;

    logic [DATA_W-1:0] y_dw;
    logic [DATA_W-1:0] y_ws;
    logic [DATA_W-1:0] y_wu;

    for (genvar i = 0; i < N_DW; i++) begin : g_dw
        assign y_dw[16*i +: 16]        = sat_s16(a[32*i +: 32]);
        assign y_dw[HALF + 16*i +: 16] = sat_s16(b[32*i +: 32]);
    end

    for (genvar i = 0; i < N_WD; i++) begin : g_wd
        assign y_ws[8*i +: 8]        = sat_s8(a[16*i +: 16]);
        assign y_ws[HALF + 8*i +: 8] = sat_s8(b[16*i +: 16]);
        assign y_wu[8*i +: 8]        = sat_u8(a[16*i +: 16]);
        assign y_wu[HALF + 8*i +: 8] = sat_u8(b[16*i +: 16]);
    end

    always_comb begin
        case (sel)
            2'd0:    y = y_dw;
            2'd1:    y = y_ws;
            2'd2:    y = y_wu;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/pkpu_unpack.sv
module pkpu_unpack
    import pkpu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              hi,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    localparam int HALF  = DATA_W / 2;
    localparam int N_GRN = 3;

    logic [HALF-1:0]               src_a;
    logic [HALF-1:0]               src_b;
    logic [N_GRN-1:0][DATA_W-1:0]  y_g;

    assign src_a = hi ? a[DATA_W-1:HALF] : a[HALF-1:0];
    assign src_b = hi ? b[DATA_W-1:HALF] : b[HALF-1:0];

    for (genvar g = 0; g < N_GRN; g++) begin : g_grn
        localparam int EW = 8 << g;
        localparam int NE = HALF / EW;
        for (genvar k = 0; k < NE; k++) begin : g_el
            assign y_g[g][(2*k)*EW +: EW]   = src_a[k*EW +: EW];
            assign y_g[g][(2*k+1)*EW +: EW] = src_b[k*EW +: EW];
        end
    end

    always_comb begin
        if (sel < 2'd3)
            y = y_g[sel];
        else
            y = '0;
    end

endmodule

// File: rtl/pkpu_top.sv
module pkpu_top
    import pkpu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [3:0]        in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result
);
    localparam int HALF = DATA_W / 2;

    dec_t              dec;
    logic [DATA_W-1:0] pack_y;
    logic [DATA_W-1:0] unpk_y;
    logic [DATA_W-1:0] next_y;
    logic              vld_q;
    logic [DATA_W-1:0] res_q;

    assign dec = decode(in_op);

    pkpu_pack #(.DATA_W(DATA_W)) u_pack (
        .sel (dec.sel),
        .a   (in_a),
        .b   (in_b),
        .y   (pack_y)
    );

    pkpu_unpack #(.DATA_W(DATA_W)) u_unpk (
        .hi  (dec.hi),
        .sel (dec.sel),
        .a   (in_a),
        .b   (in_b),
        .y   (unpk_y)
    );

    always_comb begin
        case (dec.fam)
            FAM_PACK: next_y = pack_y;
            FAM_UNPK: next_y = unpk_y;
            default:  next_y = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid)
                res_q <= next_y;
        end
    end

    assign out_valid  = vld_q;
    assign out_result = res_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R3
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));

    // R6
    neg_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_PK_WB_U && in_a[15]) |=> (out_result[7:0] == 8'h00));

    // R9
    hi_dword_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_UP_HI_D) |=>
            (out_result[HALF-1:0] == $past(in_a[DATA_W-1:HALF])
             && out_result[DATA_W-1:HALF] == $past(in_b[DATA_W-1:HALF])));

    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op[1:0] == 2'd3) |=> (out_result == '0));

endmodule

// File: tb/sim_pkpu_top.sv
module sim_pkpu_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_valid;
    logic [63:0] out_result;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] exp_res = '0;
    logic        exp_vld = 1'b0;
    string       exp_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    pkpu_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result)
    );

    function automatic longint clampi(longint v, longint lo, longint hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic logic [63:0] model(logic [3:0] op, logic [63:0] a, logic [63:0] b);
        logic [63:0] r = '0;
        int ew;
        int base;
        case (op)
            4'd0: begin
                for (int k = 0; k < 2; k++) begin
                    longint va = longint'($signed(a[32*k +: 32]));
                    longint vb = longint'($signed(b[32*k +: 32]));
                    r[16*k +: 16]      = 16'(clampi(va, -32768, 32767));
                    r[32 + 16*k +: 16] = 16'(clampi(vb, -32768, 32767));
                end
            end
            4'd1, 4'd2: begin
                for (int k = 0; k < 4; k++) begin
                    longint va = longint'($signed(a[16*k +: 16]));
                    longint vb = longint'($signed(b[16*k +: 16]));
                    if (op == 4'd1) begin
                        r[8*k +: 8]      = 8'(clampi(va, -128, 127));
                        r[32 + 8*k +: 8] = 8'(clampi(vb, -128, 127));
                    end else begin
                        r[8*k +: 8]      = 8'(clampi(va, 0, 255));
                        r[32 + 8*k +: 8] = 8'(clampi(vb, 0, 255));
                    end
                end
            end
            4'd4, 4'd5, 4'd6, 4'd8, 4'd9, 4'd10: begin
                ew   = 8 << op[1:0];
                base = op[3] ? 32 : 0;
                for (int k = 0; k < 32 / ew; k++) begin
                    for (int t = 0; t < ew; t++) begin
                        r[2*k*ew + t]     = a[base + k*ew + t];
                        r[(2*k+1)*ew + t] = b[base + k*ew + t];
                    end
                end
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(logic [3:0] op);
        case (op)
            4'd0: return "R4/R7";
            4'd1: return "R5/R7";
            4'd2: return "R6/R7";
            4'd4, 4'd5, 4'd6: return "R8/R10";
            4'd8, 4'd9, 4'd10: return "R9/R10";
            default: return "R11";
        endcase
    endfunction

    // Behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            exp_vld = 1'b0;
            exp_res = '0;
            exp_tag = "R1";
        end else begin
            exp_vld = in_valid;
            if (in_valid) begin
                exp_res = model(in_op, in_a, in_b);
                exp_tag = tag_of(in_op);
            end else begin
                exp_tag = "R3";
            end
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (out_valid !== exp_vld) begin
                errors++;
                $display("FAIL R2 valid: actual %b expected %b", out_valid, exp_vld);
            end
            checks++;
            if (out_result !== exp_res) begin
                errors++;
                $display("FAIL %s result op=%0d: actual %h expected %h", exp_tag, in_op, out_result, exp_res);
            end
        end
    end

    task automatic drive(input logic v, input logic [3:0] op, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        #1;
        in_valid = v;
        in_op    = op;
        in_a     = a;
        in_b     = b;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        // R4 edges of the signed doubleword range
        drive(1, 4'd0, 64'h0000_8000_0000_7fff, 64'hffff_7fff_ffff_8000);
        drive(1, 4'd0, 64'h8000_0000_7fff_ffff, 64'hffff_fffe_0000_0005);
        // R5 edges of the signed byte range
        drive(1, 4'd1, 64'h0080_007f_ff80_ff7f, 64'h8000_7fff_ffff_0001);
        // R3 idle cycles must hold the last result
        drive(0, 4'd2, 64'hffff_ffff_ffff_ffff, 64'h0123_4567_89ab_cdef);
        drive(0, 4'd5, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
        // R6 unsigned byte clamps
        drive(1, 4'd2, 64'h0100_00ff_ffff_8000, 64'h7fff_0000_0080_0001);
        // R8 / R9 / R10 distinct bytes expose any misplacement
        for (int op = 4; op <= 10; op++) begin
            if (op != 7)
                drive(1, 4'(op), 64'h8786_8584_8382_8180, 64'hc7c6_c5c4_c3c2_c1c0);
        end
        // R11 reserved codes
        drive(1, 4'd3, 64'hdead_beef_dead_beef, 64'h1);
        drive(1, 4'd7, 64'h1, 64'h2);
        drive(1, 4'd15, 64'h3, 64'h4);
        // Mixed traffic
        for (int n = 0; n < 300; n++) begin
            drive(1'($urandom_range(0, 3) != 0), 4'($urandom_range(0, 15)),
                  {$urandom, $urandom}, {$urandom, $urandom});
        end
        // R1 reset in mid-traffic
        drive(1, 4'd9, 64'h0102_0304_0506_0708, 64'h1112_1314_1516_1718);
        @(negedge clk);
        #1 rst = 1'b1;
        drive(1, 4'd0, 64'h1, 64'h2);
        drive(0, 4'd0, 64'h0, 64'h0);
        #1 rst = 1'b0;
        drive(1, 4'd10, 64'haaaa_bbbb_cccc_dddd, 64'h1111_2222_3333_4444);
        drive(0, 4'd0, 64'h0, 64'h0);
        repeat (3) @(negedge clk);
        #2;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule